// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital side of a dual-slope integrating analog-to-digital converter. A start request begins a conversion. The block first connects the unknown input to an external integrator for a fixed window of 2^N clocks. It then switches the integrator over to a reference of opposite polarity, clears its counter and counts clocks until an external comparator reports that the integrator output is back at or below zero. The integrator, reference and comparator are analog parts outside the block. The block only drives three switch-select lines and reads one comparator line.

The run-down count is the digital result. Because the run-up window is fixed, the count is proportional to the ratio of the input to the reference. After the run-down, the integrator is held in reset for a programmable number of clocks. A one-cycle done pulse then presents the result together with an overrange flag.

The comparator line is asynchronous, so it passes through a two-flop synchroniser. The block removes the synchroniser latency from the captured count. A run-down that never finds a zero crossing is cut short: the result saturates and is flagged as overrange. Start requests that arrive while a conversion is in progress are ignored.

Top module: `dslope_ctrl`

## Requirements
- R1: After reset, sel_in_o, sel_ref_o, int_rst_o, done_o and ovr_o are low and result_o is zero.
- R2: A start_i sampled high while idle raises sel_in_o at the next clock edge, and sel_in_o stays high for exactly 2^N clocks.
- R3: At most one of sel_in_o, sel_ref_o and int_rst_o is high in any cycle. They follow each other without gaps, in the order sel_in_o, sel_ref_o, int_rst_o.
- R4: The run-down count restarts from zero when sel_ref_o rises. cmp_zero_i is active high and means the integrator is at or below zero. Count the run-down cycles from 0 at the rise of sel_ref_o, and let j be the cycle in which cmp_zero_i goes high and then stays high. The result is then j, and sel_ref_o lasts j+3 cycles. If cmp_zero_i is already high two cycles before the run-down starts, the result is 0 and sel_ref_o lasts 1 cycle.
- R5: Every j from 0 up to and including 2^N+1 is reported exactly, with ovr_o low. A full-scale input, where j = 2^N, yields 2^N.
- R6: If cmp_zero_i is not high in any run-down cycle up to and including cycle 2^N+1, the run-down ends after 2^N+4 cycles. result_o is then all ones (2^(N+1)-1) and ovr_o is high.
- R7: int_rst_o is high for exactly RST_CYC clocks, starting in the cycle after sel_ref_o falls.
- R8: done_o is high for exactly one cycle, in the cycle after int_rst_o falls. result_o and ovr_o are valid in that cycle and hold until the next conversion's capture.
- R9: start_i is ignored in every state other than idle. It neither restarts nor extends a conversion, and it does not queue a new one.
- R10: ovr_o is cleared by the next conversion that finds a zero crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_zero_i | input | 1 | Asynchronous comparator, high when the integrator is at or below zero |
| sel_in_o | output | 1 | Connects the unknown input to the integrator (run-up) |
| sel_ref_o | output | 1 | Connects the opposite-polarity reference (run-down) |
| int_rst_o | output | 1 | Shorts the integrator back to zero |
| done_o | output | 1 | One-cycle pulse when result_o and ovr_o are valid |
| result_o | output | N+1 | Run-down count, saturated to all ones on overrange |
| ovr_o | output | 1 | No zero crossing was found within the run-down limit |

## Verification
The assertions take for granted that cmp_zero_i behaves like a real integrator's comparator. It is high whenever the integrator sits at zero, including while the integrator is held in reset, and once it goes high during run-down it stays high until the reset phase. The bench keeps to this by deriving cmp_zero_i from a behavioural integrator. The integrator adds the input level each run-up clock, subtracts a reference scaled by 2^N each run-down clock, and is cleared by int_rst_o. Random input levels span zero to slightly above the overrange limit. Random start pulses are injected only after a conversion has begun.

// File: rtl/dslope_pkg.sv
`timescale 1ns/1ps
package dslope_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUNUP  = 3'd1,
    ST_RUNDN  = 3'd2,
    ST_RSTINT = 3'd3,
    ST_DONE   = 3'd4
  } dsc_state_e;

  // flops between the comparator pin and the sequencer
  localparam int unsigned SYNC_LAT = 2;
endpackage

// File: rtl/dslope_bitsync.sv
`timescale 1ns/1ps
module dslope_bitsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dslope_counter.sv
`timescale 1ns/1ps
module dslope_counter #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dslope_fsm.sv
`timescale 1ns/1ps
module dslope_fsm
  import dslope_pkg::*;
#(
  parameter int unsigned N       = 8,
  parameter int unsigned RST_CYC = 4,
  parameter int unsigned CW      = N + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          zc_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cnt_clr_o,
  output logic          cnt_en_o,
  output logic          sel_in_o,
  output logic          sel_ref_o,
  output logic          int_rst_o,
  output logic          done_o,
  output logic [N:0]    result_o,
  output logic          ovr_o
);
  localparam int unsigned RW         = N + 1;
  localparam int unsigned RUNUP_LAST = (1 << N) - 1;
  localparam int unsigned RD_LIMIT   = (1 << N) + 1 + SYNC_LAT;
  localparam int unsigned RST_LAST   = RST_CYC - 1;

  dsc_state_e state_q, state_d;
  logic [RW-1:0] res_q, res_d;
  logic          ovr_q, ovr_d;
  logic          cap_en, sat_en;
  logic [CW-1:0] adj_cnt;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_RUNUP;
      ST_RUNUP:  if (cnt_i == CW'(RUNUP_LAST)) state_d = ST_RUNDN;
      ST_RUNDN:  if (zc_i || (cnt_i == CW'(RD_LIMIT))) state_d = ST_RSTINT;
      ST_RSTINT: if (cnt_i == CW'(RST_LAST)) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cnt_clr_o = (state_d != state_q);
  assign cnt_en_o  = (state_q == ST_RUNUP) || (state_q == ST_RUNDN) ||
                     (state_q == ST_RSTINT);

  // capture: remove synchroniser latency, floor at zero
  assign cap_en  = (state_q == ST_RUNDN) && zc_i;
  assign sat_en  = (state_q == ST_RUNDN) && !zc_i && (cnt_i == CW'(RD_LIMIT));
  assign adj_cnt = (cnt_i >= CW'(SYNC_LAT)) ? (cnt_i - CW'(SYNC_LAT)) : '0;

  always_comb begin
    res_d = res_q;
    ovr_d = ovr_q;
    if (cap_en) begin
      res_d = adj_cnt[RW-1:0];
      ovr_d = 1'b0;
    end else if (sat_en) begin
      res_d = '1;
      ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovr_q <= 1'b0;
    end else if (cap_en || sat_en) begin
      res_q <= res_d;
      ovr_q <= ovr_d;
    end
  end

  assign sel_in_o  = (state_q == ST_RUNUP);
  assign sel_ref_o = (state_q == ST_RUNDN);
  assign int_rst_o = (state_q == ST_RSTINT);
  assign done_o    = (state_q == ST_DONE);
  assign result_o  = res_q;
  assign ovr_o     = ovr_q;

  AST_RUNUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_in_o) |-> $past(cnt_i) == CW'(RUNUP_LAST)); // R2
  AST_RUNUP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_in_o) |-> $past(start_i)); // R9
  AST_REF_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_in_o) |-> sel_ref_o && !int_rst_o); // R3
  AST_RST_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_ref_o) |-> int_rst_o && !sel_in_o); // R3
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ref_o) |-> cnt_i == '0); // R4
  AST_RUNDN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ref_o |-> cnt_i <= CW'(RD_LIMIT)); // R6
  AST_RSTINT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst_o) |-> done_o && ($past(cnt_i) == CW'(RST_LAST))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !sel_in_o); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_in_o || done_o) |=> $stable(result_o) && $stable(ovr_o)); // R8
  AST_OVR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> result_o == '1); // R6
endmodule

// File: rtl/dslope_ctrl.sv
`timescale 1ns/1ps
module dslope_ctrl
  import dslope_pkg::*;
#(
  parameter int unsigned N       = 8,
  parameter int unsigned RST_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       cmp_zero_i,
  output logic       sel_in_o,
  output logic       sel_ref_o,
  output logic       int_rst_o,
  output logic       done_o,
  output logic [N:0] result_o,
  output logic       ovr_o
);
  localparam int unsigned CW = N + 2;

  logic          rst_sync_n;
  logic          zc_sync;
  logic          cnt_clr, cnt_en;
  logic [CW-1:0] cnt;

  dslope_bitsync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  dslope_bitsync #(.STAGES(SYNC_LAT)) u_cmp_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (cmp_zero_i),
    .q_o   (zc_sync)
  );

  dslope_counter #(.W(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  dslope_fsm #(.N(N), .RST_CYC(RST_CYC), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .zc_i      (zc_sync),
    .cnt_i     (cnt),
    .cnt_clr_o (cnt_clr),
    .cnt_en_o  (cnt_en),
    .sel_in_o  (sel_in_o),
    .sel_ref_o (sel_ref_o),
    .int_rst_o (int_rst_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .ovr_o     (ovr_o)
  );

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({sel_in_o, sel_ref_o, int_rst_o, done_o}) <= 1); // R3
endmodule

// File: tb/dslope_ctrl_bench.sv
`timescale 1ns/1ps
module dslope_ctrl_bench;
  localparam int N       = 8;
  localparam int RST_CYC = 4;
  localparam int FS      = 1 << N;
  localparam int SAT     = (1 << (N + 1)) - 1;

  logic       clk, rst_n, start, cmp_zero;
  logic       sel_in, sel_ref, int_rst, done, ovr;
  logic [N:0] result;

  int total = 0;
  int fails = 0;
  int vin_r = 0;
  int integ;

  dslope_ctrl #(.N(N), .RST_CYC(RST_CYC)) u_dslope_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cmp_zero_i (cmp_zero),
    .sel_in_o   (sel_in),
    .sel_ref_o  (sel_ref),
    .int_rst_o  (int_rst),
    .done_o     (done),
    .result_o   (result),
    .ovr_o      (ovr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural integrator and zero comparator
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       integ <= 0;
    else if (int_rst) integ <= 0;
    else if (sel_in)  integ <= integ + vin_r;
    else if (sel_ref) integ <= integ - FS;
  end
  assign cmp_zero = (integ <= 0);

  function automatic int exp_result(input int v);
    return (v > FS + 1) ? SAT : v;
  endfunction

  function automatic int exp_ref_len(input int v);
    if (v == 0) return 1;
    if (v <= FS + 1) return v + 3;
    return FS + 4;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input int v, input bit noisy);
    int n_in, n_ref, n_rst, guard, bad_order, overlap;
    n_in = 0; n_ref = 0; n_rst = 0; guard = 0; bad_order = 0; overlap = 0;
    vin_r = v;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && guard < 4000) begin
      if ((32'(sel_in) + 32'(sel_ref) + 32'(int_rst)) > 1) overlap++;
      if (sel_in && (n_ref > 0 || n_rst > 0)) bad_order++;
      if (sel_ref && n_rst > 0) bad_order++;
      if (!sel_in && !sel_ref && !int_rst) bad_order++;
      if (sel_in)  n_in++;
      if (sel_ref) n_ref++;
      if (int_rst) n_rst++;
      start = noisy ? (($urandom % 5) == 0) : 1'b0;
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(noisy ? "R9 run-up length under stray starts" : "R2 run-up length", n_in, FS);
    chk("R3 overlap or gap between selects", overlap + bad_order, 0);
    chk("R4 run-down duration", n_ref, exp_ref_len(v));
    if (v > FS + 1) chk("R6 saturated result", 32'(result), SAT);
    else if (v == FS) chk("R5 full-scale result", 32'(result), FS);
    else chk("R4 result", 32'(result), exp_result(v));
    chk((v > FS + 1) ? "R6 overrange flag" : "R10 overrange clear", 32'(ovr), (v > FS + 1) ? 1 : 0);
    chk("R7 integrator reset length", n_rst, RST_CYC);
    chk("R8 done seen", 32'(done), 1);
    @(negedge clk);
    chk("R8 done single cycle", 32'(done), 0);
    chk("R8 result held", 32'(result), exp_result(v));
    @(negedge clk);
    if (noisy) chk("R9 no queued start", 32'(sel_in), 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sel_in at reset", 32'(sel_in), 0);
    chk("R1 sel_ref at reset", 32'(sel_ref), 0);
    chk("R1 int_rst at reset", 32'(int_rst), 0);
    chk("R1 done at reset", 32'(done), 0);
    chk("R1 result at reset", 32'(result), 0);
    chk("R1 ovr at reset", 32'(ovr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", 32'(sel_in) + 32'(sel_ref) + 32'(int_rst), 0);

    convert(0, 1'b0);
    convert(1, 1'b0);
    convert(2, 1'b0);
    convert(FS - 1, 1'b0);
    convert(FS, 1'b0);
    convert(FS + 1, 1'b0);
    convert(FS + 2, 1'b0);
    convert(FS + 7, 1'b1);
    convert(5, 1'b1);
    for (int i = 0; i < 24; i++) begin
      convert(int'($urandom_range(0, FS + 4)), 1'(($urandom % 2) == 0));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule